// File: doc/BRIEF.md
# Frame Clock Ratio Monitor

The block watches two asynchronous frame clocks, one for an input audio port and one for an output audio port. It counts how many reference-clock cycles fall between successive rising edges of each frame clock. It then flags frame rates that are too fast, or too slow, for the reference clock under the current master/slave setting of the two ports. The reference clock is the crystal or oscillator clock that the ports share, and all logic runs on it. Each frame clock passes through a two-flop synchronizer before its rising edges are detected.

The minimum count depends on the port setting. A port that is master needs at least 128 reference cycles per frame, and the port opposite a master needs at least 130. When both ports are slave, each port needs at least 130 cycles per frame and fewer than 3750. Both ports set to master is an illegal setting and is reported as such. Each port has a live flag that follows its latest measurement and a sticky flag that holds until software clears it. A valid output marks when the flags can be trusted.

Top module: `frame_ratio_mon`

## Requirements
- R1: Each count output holds the number of reference cycles between the two most recent synchronized rising edges of that port's frame clock. A frame clock with a period of exactly P reference cycles reads as P.
- R2: The measured count saturates at 2^CNT_W-1 (4095 by default) and never wraps.
- R3: flags_valid_o is low until each port has seen three rising edges, which is two complete periods, after reset or after any change of the master bits. While flags_valid_o is low, both live flags are low.
- R4: With only the input port master (in_master_i=1, out_master_i=0), an input count below 128 raises in_live_o and an output count below 130 raises out_live_o. An input count of 129 raises nothing.
- R5: With only the output port master, an output count below 128 raises out_live_o and an input count below 130 raises in_live_o.
- R6: With both ports slave, a count below 130 on either port raises that port's live flag. Counts of exactly 130 do not.
- R7: With both ports slave, a count of 3750 or more raises that port's live flag and 3749 does not. With either port master, there is no upper limit.
- R8: A sticky flag sets whenever its live flag is set and stays set after the violation is gone. A clr_i pulse clears it unless a violation is present in that same cycle.
- R9: With both master bits high, cfg_err_o is high and flags_valid_o and both live flags stay low.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_fclk_i | input | 1 | Input-port frame clock, asynchronous |
| out_fclk_i | input | 1 | Output-port frame clock, asynchronous |
| in_master_i | input | 1 | Input port is master |
| out_master_i | input | 1 | Output port is master |
| clr_i | input | 1 | One-cycle pulse that clears the sticky flags |
| in_count_o | output | CNT_W | Last measured input period, in reference cycles |
| out_count_o | output | CNT_W | Last measured output period, in reference cycles |
| flags_valid_o | output | 1 | The live and sticky updates can be trusted |
| in_live_o | output | 1 | The latest input measurement violates its limit |
| out_live_o | output | 1 | The latest output measurement violates its limit |
| in_sticky_o | output | 1 | Input violation seen since the last clear |
| out_sticky_o | output | 1 | Output violation seen since the last clear |
| cfg_err_o | output | 1 | Both ports are set to master |

## Verification
The bench builds the block with its default parameters: CNT_W=12, limits of 128, 130 and 3750, and a two-flop synchronizer. These values put both the 3749/3750 upper edge and the 4095 saturation point within a run of a few tens of thousands of cycles. The frame clocks are generated with an exact period in reference cycles, so every limit can be probed one count below and at the boundary, in each port setting.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum int unsigned {
    PORT_IN  = 0,
    PORT_OUT = 1
  } port_e;

  localparam int unsigned NUM_PORTS = 2;

  function automatic logic over_limit(
    input int unsigned meas,
    input logic        self_master,
    input logic        peer_master,
    input int unsigned master_min,
    input int unsigned slave_min,
    input int unsigned slave_max
  );
    int unsigned lo;
    logic        hi_en;
    lo    = self_master ? master_min : slave_min;
    hi_en = !self_master && !peer_master;
    return (meas < lo) || (hi_en && (meas >= slave_max));
  endfunction
endpackage

// File: rtl/frm_sync.sv
module frm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/frm_period.sv
module frm_period #(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned READY_EDGES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int unsigned      RC_W    = $clog2(READY_EDGES + 1);
  localparam logic [RC_W-1:0]  RC_TOP  = RC_W'(READY_EDGES);

  logic [CNT_W-1:0] run_q;
  logic [RC_W-1:0]  edges_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      meas_o <= '0;
    end else if (rise_i) begin
      meas_o <= run_q;
      run_q  <= CNT_W'(1);
    end else if (run_q != CNT_MAX) begin
      run_q  <= run_q + 1'b1;
    end
  end

  // edges seen since reset or restart, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          edges_q <= '0;
    else if (restart_i)                   edges_q <= '0;
    else if (rise_i && edges_q != RC_TOP) edges_q <= edges_q + 1'b1;
  end

  assign ready_o = (edges_q == RC_TOP);
endmodule

// File: rtl/frame_ratio_mon.sv
module frame_ratio_mon
  import frm_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned SYNC_STG   = 2,
  parameter int unsigned MASTER_MIN = 128,
  parameter int unsigned SLAVE_MIN  = 130,
  parameter int unsigned SLAVE_MAX  = 3750
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_fclk_i,
  input  logic             out_fclk_i,
  input  logic             in_master_i,
  input  logic             out_master_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] in_count_o,
  output logic [CNT_W-1:0] out_count_o,
  output logic             flags_valid_o,
  output logic             in_live_o,
  output logic             out_live_o,
  output logic             in_sticky_o,
  output logic             out_sticky_o,
  output logic             cfg_err_o
);
  logic [NUM_PORTS-1:0] fclk, master_d, mode_q, rise, ready, viol, live_q, sticky_q;
  logic [CNT_W-1:0]     meas [NUM_PORTS];
  logic                 mode_chg, bad_cfg, valid_c, valid_q, cfg_err_q;

  assign fclk[PORT_IN]      = in_fclk_i;
  assign fclk[PORT_OUT]     = out_fclk_i;
  assign master_d[PORT_IN]  = in_master_i;
  assign master_d[PORT_OUT] = out_master_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= master_d;
  end

  assign mode_chg = (master_d != mode_q);
  assign bad_cfg  = &mode_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    frm_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(fclk[p]),
      .rise_o (rise[p])
    );

    frm_period #(.CNT_W(CNT_W), .READY_EDGES(3)) u_period (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rise_i   (rise[p]),
      .restart_i(mode_chg),
      .meas_o   (meas[p]),
      .ready_o  (ready[p])
    );

    assign viol[p] = over_limit(32'(meas[p]), mode_q[p], mode_q[NUM_PORTS-1-p],
                                MASTER_MIN, SLAVE_MIN, SLAVE_MAX);
  end

  assign valid_c = (&ready) && !bad_cfg && !mode_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      live_q    <= '0;
      sticky_q  <= '0;
      cfg_err_q <= 1'b0;
    end else begin
      valid_q   <= valid_c;
      live_q    <= {NUM_PORTS{valid_c}} & viol;
      // a violation in the clear cycle wins
      sticky_q  <= (sticky_q & ~{NUM_PORTS{clr_i}}) | ({NUM_PORTS{valid_c}} & viol);
      cfg_err_q <= bad_cfg;
    end
  end

  assign in_count_o    = meas[PORT_IN];
  assign out_count_o   = meas[PORT_OUT];
  assign flags_valid_o = valid_q;
  assign in_live_o     = live_q[PORT_IN];
  assign out_live_o    = live_q[PORT_OUT];
  assign in_sticky_o   = sticky_q[PORT_IN];
  assign out_sticky_o  = sticky_q[PORT_OUT];
  assign cfg_err_o     = cfg_err_q;
endmodule

// File: rtl/frame_ratio_mon_chk.sv
module frame_ratio_mon_chk #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned SLAVE_MIN = 130,
  parameter int unsigned SLAVE_MAX = 3750
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic [CNT_W-1:0] in_count_o,
  input logic [CNT_W-1:0] out_count_o,
  input logic             flags_valid_o,
  input logic             in_live_o,
  input logic             out_live_o,
  input logic             in_sticky_o,
  input logic             out_sticky_o,
  input logic             cfg_err_o
);
  a_r3_live_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_live_o || out_live_o) |-> flags_valid_o);

  a_r8_live_sets_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_live_o |-> in_sticky_o) and (out_live_o |-> out_sticky_o));

  a_r8_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sticky_o && !clr_i) |=> in_sticky_o);

  a_r8_out_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sticky_o && !clr_i) |=> out_sticky_o);

  a_r9_cfg_blocks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !flags_valid_o);

  // R6 R7: a live flag always has an out-of-range count behind it
  a_r6_live_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_live_o) |-> (32'($past(in_count_o)) < SLAVE_MIN || 32'($past(in_count_o)) >= SLAVE_MAX));

  a_r7_out_live_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_live_o) |-> (32'($past(out_count_o)) < SLAVE_MIN || 32'($past(out_count_o)) >= SLAVE_MAX));
endmodule

bind frame_ratio_mon frame_ratio_mon_chk #(
  .CNT_W    (CNT_W),
  .SLAVE_MIN(SLAVE_MIN),
  .SLAVE_MAX(SLAVE_MAX)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_i        (clr_i),
  .in_count_o   (in_count_o),
  .out_count_o  (out_count_o),
  .flags_valid_o(flags_valid_o),
  .in_live_o    (in_live_o),
  .out_live_o   (out_live_o),
  .in_sticky_o  (in_sticky_o),
  .out_sticky_o (out_sticky_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/sim_frame_ratio_mon.sv
module sim_frame_ratio_mon;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_fclk = 1'b0, out_fclk = 1'b0;
  logic in_m = 1'b0, out_m = 1'b0, clr = 1'b0;
  logic [CNT_W-1:0] in_cnt, out_cnt;
  logic valid, in_live, out_live, in_stk, out_stk, cfg_err;

  int in_per = 0, out_per = 0, in_ph = 0, out_ph = 0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  // frame clocks with an exact period in reference cycles; 0 holds low
  always @(negedge clk) begin
    if (in_per == 0) begin in_ph = 0; in_fclk = 1'b0; end
    else begin
      in_ph   = (in_ph >= in_per - 1) ? 0 : in_ph + 1;
      in_fclk = (in_ph < in_per / 2);
    end
    if (out_per == 0) begin out_ph = 0; out_fclk = 1'b0; end
    else begin
      out_ph   = (out_ph >= out_per - 1) ? 0 : out_ph + 1;
      out_fclk = (out_ph < out_per / 2);
    end
  end

  frame_ratio_mon u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_fclk_i(in_fclk), .out_fclk_i(out_fclk),
    .in_master_i(in_m), .out_master_i(out_m), .clr_i(clr),
    .in_count_o(in_cnt), .out_count_o(out_cnt), .flags_valid_o(valid),
    .in_live_o(in_live), .out_live_o(out_live), .in_sticky_o(in_stk),
    .out_sticky_o(out_stk), .cfg_err_o(cfg_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input bit im, input bit om, input int ip, input int op);
    in_m = im; out_m = om; in_per = ip; out_per = op;
    cycles(4 * ((ip > op) ? ip : op) + 40);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; cycles(1); clr = 1'b0; cycles(2);
  endtask

  task automatic t_reset();
    cycles(5);
    check("R10", "in_count", int'(in_cnt), 0);
    check("R10", "out_count", int'(out_cnt), 0);
    check("R10", "flags", int'({valid, in_live, out_live, in_stk, out_stk, cfg_err}), 0);
  endtask

  task automatic t_basic();
    setup(0, 0, 200, 300);
    check("R1", "in_count", int'(in_cnt), 200);
    check("R1", "out_count", int'(out_cnt), 300);
    check("R3", "valid", int'(valid), 1);
    check("R6", "live", int'({in_live, out_live}), 0);
    out_per = 257; cycles(4 * 257 + 40);
    check("R1", "out_count odd period", int'(out_cnt), 257);
  endtask

  task automatic t_not_valid_early();
    in_m = 1'b1; cycles(10);
    check("R3", "valid after mode change", int'(valid), 0);
    check("R3", "live while invalid", int'({in_live, out_live}), 0);
    cycles(4 * 300 + 40);
    check("R3", "valid regained", int'(valid), 1);
  endtask

  task automatic t_in_master();
    setup(1, 0, 129, 130);
    check("R4", "live at 129/130", int'({in_live, out_live}), 0);
    setup(1, 0, 128, 129);
    check("R4", "in_live at 128", int'(in_live), 0);
    check("R4", "out_live at 129", int'(out_live), 1);
    setup(1, 0, 127, 200);
    check("R4", "in_live at 127", int'(in_live), 1);
    check("R4", "out_live at 200", int'(out_live), 0);
  endtask

  task automatic t_out_master();
    setup(0, 1, 130, 128);
    check("R5", "live at 130/128", int'({in_live, out_live}), 0);
    setup(0, 1, 129, 127);
    check("R5", "in_live at 129", int'(in_live), 1);
    check("R5", "out_live at 127", int'(out_live), 1);
  endtask

  task automatic t_slave_min();
    setup(0, 0, 129, 130);
    check("R6", "in_live at 129", int'(in_live), 1);
    check("R6", "out_live at 130", int'(out_live), 0);
  endtask

  task automatic t_slave_max();
    setup(0, 0, 3749, 3750);
    check("R7", "in_live at 3749", int'(in_live), 0);
    check("R7", "out_live at 3750", int'(out_live), 1);
    setup(1, 0, 3800, 3800);
    check("R7", "no upper bound with master", int'({in_live, out_live}), 0);
  endtask

  task automatic t_sticky();
    setup(0, 0, 200, 200);
    pulse_clr();
    check("R8", "cleared", int'({in_stk, out_stk}), 0);
    setup(0, 0, 100, 200);
    check("R8", "in sticky set", int'(in_stk), 1);
    setup(0, 0, 200, 200);
    check("R8", "live gone", int'(in_live), 0);
    check("R8", "sticky held", int'(in_stk), 1);
    pulse_clr();
    check("R8", "sticky cleared by clr", int'(in_stk), 0);
  endtask

  task automatic t_saturate();
    setup(0, 1, 5000, 200);
    check("R2", "in_count saturated", int'(in_cnt), 4095);
  endtask

  task automatic t_cfg();
    setup(1, 1, 200, 100);
    check("R9", "cfg_err", int'(cfg_err), 1);
    check("R9", "valid", int'(valid), 0);
    check("R9", "live", int'({in_live, out_live}), 0);
  endtask

  initial begin
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_not_valid_early();
    t_in_master();
    t_out_master();
    t_slave_min();
    t_slave_max();
    t_sticky();
    t_saturate();
    t_cfg();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule